// File: doc/BRIEF.md
# Three-Dimensional DMA Address Sequencer

This block keeps the transfer parameters of a single DMA channel and turns each trigger into a short run of byte-burst requests. The parameters are:

- a source and a destination base address;
- an element length A in bytes;
- a count B of arrays per frame;
- a count C of frames;
- separate signed array and frame strides for each side.

Each request carries a source address, a destination address and a length. It leaves on a valid/ready handshake. Data movement and bus protocol belong to a downstream engine.

The channel works in one of two synchronisation modes:

- **Array-synchronised:** one trigger moves a single A-byte array, so a full block of A×B×C bytes takes B×C triggers.
- **Frame-synchronised:** one trigger moves a whole frame of B arrays, so a block takes C triggers.

The remaining counts and the current addresses are kept between triggers. At the end of each trigger's portion the block raises a one-cycle completion pulse. A final flag beside the pulse marks the portion that used up the block.

A trigger that comes while a portion is running is remembered and served afterwards. A trigger that comes with nothing left to move is reported as a null-transfer error.

Top module: `dma3d_seq`

## Requirements
- R1: After reset, `req_valid`, `xfer_done` and `null_err` are all 0.
- R2: Each request has `req_len` equal to the loaded A. While `req_valid` is 1 and `req_ready` is 0, the request stays valid and its address and length stay unchanged.
- R3: Within a frame, each accepted request advances the source address by the sign-extended 16-bit source array stride, and the destination address by the destination array stride. The first request of a freshly loaded block uses the two base addresses.
- R4: After the last array of a frame is accepted, the next request starts on each side at that side's previous frame start plus its sign-extended 16-bit frame stride.
- R5: With `cfg_frame_sync`=0 (array-synchronised), a trigger yields exactly one request, and the whole block takes B×C triggers.
- R6: With `cfg_frame_sync`=1 (frame-synchronised), a trigger yields B requests and the C count drops by one per frame. The block takes C triggers, so with C=1 a single trigger moves one A×B frame and then stops.
- R7: `xfer_done` pulses for exactly one cycle, in the cycle after the edge on which a portion's last request is accepted. `xfer_final` is 1 only together with that pulse, and only for the portion that exhausts all counts.
- R8: A trigger that arrives while a portion is running, including on the edge of its last accept, is held in a one-deep pending flag. That portion's first request is presented two cycles after the end edge.
- R9: A trigger taken while no counts remain produces a one-cycle `null_err` pulse, one cycle later, and no request. Loading A, B or C as zero leaves the channel with no counts remaining.
- R10: `cfg_load` has priority over everything else. It cancels any running portion and any pending trigger, and installs the new parameters; `req_valid` is 0 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_load | input | 1 | Load the parameter set below |
| cfg_frame_sync | input | 1 | 1 = frame-synchronised, 0 = array-synchronised |
| cfg_src_base | input | ADDR_W | Source base address |
| cfg_dst_base | input | ADDR_W | Destination base address |
| cfg_acnt | input | ACNT_W | Bytes per array (A) |
| cfg_bcnt | input | BCNT_W | Arrays per frame (B) |
| cfg_ccnt | input | CCNT_W | Frames per block (C) |
| cfg_src_bstride | input | STRIDE_W | Signed source array stride |
| cfg_dst_bstride | input | STRIDE_W | Signed destination array stride |
| cfg_src_cstride | input | STRIDE_W | Signed source frame stride |
| cfg_dst_cstride | input | STRIDE_W | Signed destination frame stride |
| trig | input | 1 | Transfer trigger |
| req_valid | output | 1 | Burst request valid |
| req_ready | input | 1 | Burst request accepted |
| req_src | output | ADDR_W | Burst source address |
| req_dst | output | ADDR_W | Burst destination address |
| req_len | output | ACNT_W | Burst length in bytes |
| xfer_done | output | 1 | One-cycle end-of-portion pulse |
| xfer_final | output | 1 | Portion completed the block |
| null_err | output | 1 | Trigger found no counts remaining |

## Verification
A new trigger can coincide with the edge that accepts the last request of a portion. The block must then both close the portion and capture the trigger as pending.

The bench provokes this collision in two ways:
- holding `trig` high for many cycles at a time in both modes;
- random triggers against a randomly stalling `req_ready`.

A reference model, evaluated each cycle, predicts three things for each collision:
- the done pulse with the correct final flag, one cycle after the edge;
- the gap of one idle cycle;
- the restart from the pending flag with the correct next addresses.

Collisions between a pending restart and an exhausted channel are judged as well, since they must raise `null_err` instead of a request.

// File: rtl/dma3d_pkg.sv
package dma3d_pkg;

    typedef enum logic {
        SYNC_ARRAY = 1'b0,
        SYNC_FRAME = 1'b1
    } sync_mode_e;

endpackage

// File: rtl/dma3d_addr_walk.sv
// Address walker for one side (source or destination) of the channel.
module dma3d_addr_walk #(
    parameter int ADDR_W   = 32,
    parameter int STRIDE_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  logic [ADDR_W-1:0]   base,
    input  logic [STRIDE_W-1:0] bstride,
    input  logic [STRIDE_W-1:0] cstride,
    input  logic                step_b,
    input  logic                step_c,
    output logic [ADDR_W-1:0]   cur
);
    localparam int EXT_W = ADDR_W - STRIDE_W;

    typedef struct packed {
        logic [ADDR_W-1:0]   cur;
        logic [ADDR_W-1:0]   frm;
        logic [STRIDE_W-1:0] bs;
        logic [STRIDE_W-1:0] cs;
    } walk_t;

    walk_t st_d, st_q;
    logic [ADDR_W-1:0] bs_ext, cs_ext;

    always_comb begin
        bs_ext = {{EXT_W{st_q.bs[STRIDE_W-1]}}, st_q.bs};
        cs_ext = {{EXT_W{st_q.cs[STRIDE_W-1]}}, st_q.cs};
        st_d   = st_q;
        if (load) begin
            st_d.cur = base;
            st_d.frm = base;
            st_d.bs  = bstride;
            st_d.cs  = cstride;
        end else if (step_c) begin
            st_d.frm = st_q.frm + cs_ext;
            st_d.cur = st_q.frm + cs_ext;
        end else if (step_b) begin
            st_d.cur = st_q.cur + bs_ext;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cur = st_q.cur;
endmodule

// File: rtl/dma3d_count.sv
// Array and frame counters of the channel.
module dma3d_count #(
    parameter int ACNT_W = 16,
    parameter int BCNT_W = 16,
    parameter int CCNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ACNT_W-1:0] acnt,
    input  logic [BCNT_W-1:0] bcnt,
    input  logic [CCNT_W-1:0] ccnt,
    input  logic              step,
    output logic [ACNT_W-1:0] alen,
    output logic              array_last,
    output logic              block_last,
    output logic              exhausted
);
    localparam logic [BCNT_W-1:0] B_ONE = BCNT_W'(1);
    localparam logic [CCNT_W-1:0] C_ONE = CCNT_W'(1);

    typedef struct packed {
        logic [ACNT_W-1:0] alen;
        logic [BCNT_W-1:0] brel;
        logic [BCNT_W-1:0] bleft;
        logic [CCNT_W-1:0] cleft;
    } cnt_t;

    cnt_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.alen  = acnt;
            st_d.brel  = bcnt;
            st_d.bleft = bcnt;
            st_d.cleft = (acnt == '0 || bcnt == '0) ? '0 : ccnt;
        end else if (step && st_q.cleft != '0) begin
            if (st_q.bleft == B_ONE) begin
                st_d.bleft = st_q.brel;
                st_d.cleft = st_q.cleft - C_ONE;
            end else begin
                st_d.bleft = st_q.bleft - B_ONE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign alen       = st_q.alen;
    assign array_last = (st_q.bleft == B_ONE);
    assign block_last = (st_q.bleft == B_ONE) && (st_q.cleft == C_ONE);
    assign exhausted  = (st_q.cleft == '0);
endmodule

// File: rtl/dma3d_ctrl.sv
// Trigger, pending and completion control.
module dma3d_ctrl
    import dma3d_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  sync_mode_e mode,
    input  logic       trig,
    input  logic       accept,
    input  logic       exhausted,
    input  logic       array_last,
    input  logic       block_last,
    output logic       busy,
    output logic       done,
    output logic       final_flag,
    output logic       null_err
);
    typedef struct packed {
        logic busy;
        logic pend;
        logic done;
        logic fin;
        logic nul;
    } ctl_t;

    ctl_t st_d, st_q;
    logic portion_end;

    always_comb begin
        portion_end = (mode == SYNC_ARRAY) || array_last;
        st_d      = st_q;
        st_d.done = 1'b0;
        st_d.fin  = 1'b0;
        st_d.nul  = 1'b0;
        if (load) begin
            st_d.busy = 1'b0;
            st_d.pend = 1'b0;
        end else if (st_q.busy) begin
            if (trig) st_d.pend = 1'b1;
            if (accept && portion_end) begin
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
                st_d.fin  = block_last;
            end
        end else if (trig || st_q.pend) begin
            st_d.pend = 1'b0;
            if (exhausted) st_d.nul  = 1'b1;
            else           st_d.busy = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy       = st_q.busy;
    assign done       = st_q.done;
    assign final_flag = st_q.fin;
    assign null_err   = st_q.nul;
endmodule

// File: rtl/dma3d_seq.sv
// Three-dimensional DMA address sequencer, top level.
module dma3d_seq
    import dma3d_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int STRIDE_W = 16,
    parameter int ACNT_W   = 16,
    parameter int BCNT_W   = 16,
    parameter int CCNT_W   = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_load,
    input  logic                cfg_frame_sync,
    input  logic [ADDR_W-1:0]   cfg_src_base,
    input  logic [ADDR_W-1:0]   cfg_dst_base,
    input  logic [ACNT_W-1:0]   cfg_acnt,
    input  logic [BCNT_W-1:0]   cfg_bcnt,
    input  logic [CCNT_W-1:0]   cfg_ccnt,
    input  logic [STRIDE_W-1:0] cfg_src_bstride,
    input  logic [STRIDE_W-1:0] cfg_dst_bstride,
    input  logic [STRIDE_W-1:0] cfg_src_cstride,
    input  logic [STRIDE_W-1:0] cfg_dst_cstride,
    input  logic                trig,
    output logic                req_valid,
    input  logic                req_ready,
    output logic [ADDR_W-1:0]   req_src,
    output logic [ADDR_W-1:0]   req_dst,
    output logic [ACNT_W-1:0]   req_len,
    output logic                xfer_done,
    output logic                xfer_final,
    output logic                null_err
);
    localparam int SIDES = 2;

    sync_mode_e mode_d, mode_q;
    logic busy, accept, step, step_b, step_c;
    logic array_last, block_last, exhausted;

    logic [SIDES-1:0][ADDR_W-1:0]   side_base;
    logic [SIDES-1:0][STRIDE_W-1:0] side_bs;
    logic [SIDES-1:0][STRIDE_W-1:0] side_cs;
    logic [SIDES-1:0][ADDR_W-1:0]   side_cur;

    always_comb begin
        mode_d = mode_q;
        if (cfg_load) mode_d = sync_mode_e'(cfg_frame_sync);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mode_q <= SYNC_ARRAY;
        else        mode_q <= mode_d;
    end

    assign accept = busy && req_ready;
    assign step   = accept && !cfg_load;
    assign step_c = step && array_last;
    assign step_b = step && !array_last;

    assign side_base = {cfg_dst_base, cfg_src_base};
    assign side_bs   = {cfg_dst_bstride, cfg_src_bstride};
    assign side_cs   = {cfg_dst_cstride, cfg_src_cstride};

    for (genvar s = 0; s < SIDES; s++) begin : g_side
        dma3d_addr_walk #(
            .ADDR_W  (ADDR_W),
            .STRIDE_W(STRIDE_W)
        ) walk_i (
            .clk    (clk),
            .rst_n  (rst_n),
            .load   (cfg_load),
            .base   (side_base[s]),
            .bstride(side_bs[s]),
            .cstride(side_cs[s]),
            .step_b (step_b),
            .step_c (step_c),
            .cur    (side_cur[s])
        );
    end

    dma3d_count #(
        .ACNT_W(ACNT_W),
        .BCNT_W(BCNT_W),
        .CCNT_W(CCNT_W)
    ) count_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (cfg_load),
        .acnt      (cfg_acnt),
        .bcnt      (cfg_bcnt),
        .ccnt      (cfg_ccnt),
        .step      (step),
        .alen      (req_len),
        .array_last(array_last),
        .block_last(block_last),
        .exhausted (exhausted)
    );

    dma3d_ctrl ctrl_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (cfg_load),
        .mode      (mode_q),
        .trig      (trig),
        .accept    (accept),
        .exhausted (exhausted),
        .array_last(array_last),
        .block_last(block_last),
        .busy      (busy),
        .done      (xfer_done),
        .final_flag(xfer_final),
        .null_err  (null_err)
    );

    assign req_valid = busy;
    assign req_src   = side_cur[0];
    assign req_dst   = side_cur[1];
endmodule

// File: rtl/dma3d_seq_chk.sv
module dma3d_seq_chk #(
    parameter int ADDR_W = 32,
    parameter int ACNT_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_load,
    input logic              req_valid,
    input logic              req_ready,
    input logic [ADDR_W-1:0] req_src,
    input logic [ADDR_W-1:0] req_dst,
    input logic [ACNT_W-1:0] req_len,
    input logic              xfer_done,
    input logic              xfer_final,
    input logic              null_err
);
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready && !cfg_load) |=> (req_valid && $stable(req_src) && $stable(req_dst) && $stable(req_len))); // R2
    AST_REQ_LEN_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> (req_len != '0)); // R2
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done |=> !xfer_done); // R7
    AST_FINAL_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_final |-> xfer_done); // R7
    AST_NULL_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        null_err |-> (!req_valid && !xfer_done)); // R9
    AST_LOAD_CANCELS: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_load |=> !req_valid); // R10
endmodule

bind dma3d_seq dma3d_seq_chk #(.ADDR_W(ADDR_W), .ACNT_W(ACNT_W)) chk_i (.*);

// File: tb/dma3d_seq_tb.sv
module dma3d_seq_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG_CYCLES = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_load = 1'b0;
    logic        cfg_frame_sync = 1'b0;
    logic [31:0] cfg_src_base = '0;
    logic [31:0] cfg_dst_base = '0;
    logic [15:0] cfg_acnt = '0;
    logic [15:0] cfg_bcnt = '0;
    logic [15:0] cfg_ccnt = '0;
    logic [15:0] cfg_src_bstride = '0;
    logic [15:0] cfg_dst_bstride = '0;
    logic [15:0] cfg_src_cstride = '0;
    logic [15:0] cfg_dst_cstride = '0;
    logic        trig = 1'b0;
    logic        req_ready = 1'b0;
    logic        req_valid;
    logic [31:0] req_src, req_dst;
    logic [15:0] req_len;
    logic        xfer_done, xfer_final, null_err;

    always #(CLK_PERIOD/2) clk = ~clk;

    dma3d_seq dut_i (.*);

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    // reference model state
    int unsigned m_a, m_b, m_c, m_bl, m_cl;
    bit          m_mode, m_busy, m_pend, m_frompend;
    logic [31:0] m_cs, m_cd, m_fs, m_fd;
    int          m_sbs, m_dbs, m_scs, m_dcs;
    bit          e_done, e_final, e_null;
    int          done_seen;
    int          ready_pct = 75;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic load(input int unsigned a, b, c, input bit mode,
                        input logic [31:0] sb, db,
                        input logic signed [15:0] sbs, dbs, scs, dcs);
        cfg_load = 1'b1; trig = 1'b0;
        cfg_frame_sync = mode; cfg_src_base = sb; cfg_dst_base = db;
        cfg_acnt = 16'(a); cfg_bcnt = 16'(b); cfg_ccnt = 16'(c);
        cfg_src_bstride = sbs; cfg_dst_bstride = dbs;
        cfg_src_cstride = scs; cfg_dst_cstride = dcs;
        m_a = a; m_b = b; m_c = c; m_mode = mode;
        m_cs = sb; m_fs = sb; m_cd = db; m_fd = db;
        m_sbs = int'(sbs); m_dbs = int'(dbs); m_scs = int'(scs); m_dcs = int'(dcs);
        m_bl = b; m_cl = (a == 0 || b == 0) ? 0 : c;
        m_busy = 0; m_pend = 0; m_frompend = 0;
        e_done = 0; e_final = 0; e_null = 0;
        done_seen = 0;
        @(negedge clk);
        cfg_load = 1'b0;
        chk(req_valid == 1'b0, "R10", 32'(req_valid), 32'd0);
    endtask

    task automatic cyc(input bit t);
        bit rdy, nd, nf, nn;
        string vt, at;
        trig = t;
        rdy = (($urandom % 100) < ready_pct);
        req_ready = rdy;
        vt = m_frompend ? "R8" : (m_mode ? "R6" : "R5");
        chk(req_valid == m_busy, vt, 32'(req_valid), 32'(m_busy));
        chk(xfer_done == e_done, "R7", 32'(xfer_done), 32'(e_done));
        chk(xfer_final == (e_done && e_final), "R7", 32'(xfer_final), 32'(e_done && e_final));
        chk(null_err == e_null, "R9", 32'(null_err), 32'(e_null));
        if (xfer_done) done_seen++;
        if (m_busy && req_valid) begin
            at = (m_bl == m_b && m_cl != m_c) ? "R4" : "R3";
            chk(req_src == m_cs, at, req_src, m_cs);
            chk(req_dst == m_cd, at, req_dst, m_cd);
            chk(req_len == 16'(m_a), "R2", 32'(req_len), m_a);
        end
        nd = 0; nf = 0; nn = 0;
        if (m_busy) begin
            if (t) m_pend = 1;
            if (rdy) begin
                bit pend_end, fin;
                pend_end = !m_mode || (m_bl == 1);
                fin = (m_bl == 1) && (m_cl == 1);
                if (m_bl == 1) begin
                    m_bl = m_b; m_cl--;
                    m_fs = m_fs + 32'(m_scs); m_fd = m_fd + 32'(m_dcs);
                    m_cs = m_fs; m_cd = m_fd;
                end else begin
                    m_bl--;
                    m_cs = m_cs + 32'(m_sbs); m_cd = m_cd + 32'(m_dbs);
                end
                if (pend_end) begin m_busy = 0; nd = 1; nf = fin; m_frompend = 0; end
            end
        end else if (t || m_pend) begin
            m_frompend = m_pend && !t;
            m_pend = 0;
            if (m_cl == 0) nn = 1;
            else m_busy = 1;
        end
        e_done = nd; e_final = nf; e_null = nn;
        @(negedge clk);
    endtask

    // run a loaded block to completion, then probe one trigger on the empty channel
    task automatic run_block(input int trig_pct);
        int exp_done;
        exp_done = (m_cl == 0) ? 0 : (m_mode ? int'(m_c) : int'(m_b * m_c));
        for (int i = 0; i < 2000; i++) begin
            if (m_cl == 0 && !m_busy && !m_pend) break;
            cyc(($urandom % 100) < trig_pct);
        end
        cyc(0); cyc(0);
        chk(done_seen == exp_done, m_mode ? "R6" : "R5", 32'(done_seen), 32'(exp_done));
        cyc(1); cyc(0); cyc(0);
    endtask

    initial begin
        void'($urandom(32'h5EED_0D3A));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_valid == 0, "R1", 32'(req_valid), 0);
        chk(xfer_done == 0, "R1", 32'(xfer_done), 0);
        chk(null_err == 0, "R1", 32'(null_err), 0);

        // frame mode, 8x2x4, positive strides, isolated triggers
        load(8, 2, 4, 1, 32'h1000, 32'h8000, 16, 16, 16, 16);
        run_block(20);
        // frame mode, C=1: one trigger, one frame
        load(8, 3, 1, 1, 32'h2000, 32'h9000, 8, 8, 64, 64);
        cyc(1); repeat (10) cyc(0);
        chk(done_seen == 1, "R6", 32'(done_seen), 1);
        // array mode, negative strides, continuous triggers (pending collisions)
        ready_pct = 100;
        load(4, 3, 2, 0, 32'h3000, 32'hA000, -16'sd4, -16'sd12, -16'sd100, 16'sd200);
        run_block(100);
        // frame mode with trig held high against ready stalls
        ready_pct = 60;
        load(2, 2, 3, 1, 32'h0, 32'hFFFF_FFF0, 16'sd2, -16'sd2, 16'sd10, -16'sd10);
        run_block(100);
        // zero counts are exhausted on load
        load(0, 2, 2, 1, 32'h10, 32'h20, 1, 1, 1, 1);
        cyc(1); cyc(0); cyc(0);
        load(4, 2, 0, 0, 32'h10, 32'h20, 1, 1, 1, 1);
        cyc(1); cyc(0); cyc(0);
        // reload mid-portion cancels
        load(4, 4, 4, 1, 32'h4000, 32'h5000, 4, 4, 32, 32);
        cyc(1); cyc(1); cyc(0);
        load(4, 2, 2, 1, 32'h6000, 32'h7000, 4, 4, 16, 16);
        run_block(30);
        // random configurations
        for (int k = 0; k < 40; k++) begin
            ready_pct = 40 + int'($urandom % 61);
            load(1 + ($urandom % 64), 1 + ($urandom % 4), 1 + ($urandom % 4), 1'($urandom % 2),
                 $urandom, $urandom, 16'($urandom), 16'($urandom), 16'($urandom), 16'($urandom));
            run_block(10 + int'($urandom % 91));
        end
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (WATCHDOG_CYCLES) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule